// File: doc/BRIEF.md
# Bulk Cache-Line Transfer Engine

This per-tile engine moves a block of memory from one core's cache into another core's cache as a run of whole cache lines. Software first loads a byte count with a size command. The receiving core then issues a receive command naming the sending core and its own destination buffer. This sends a small request packet, carrying that buffer address, across the network. The sending core issues a send command naming the receiver and its source buffer.

Streaming begins only once both the local send command and the matching request are present, in either order. The sender reads its source lines from the local cache one at a time. Each line that hits goes out as a network packet tagged with the receiver-side address. For a line that misses, the engine sends a read to the memory controller instead. That read names the receiving core as the requester and the receiver-side address as the target, so the memory reply goes straight to the receiver.

On the receiving side each arriving line is written into the local cache at the address carried in the packet. The transfer completes once the bytes received reach the preset size or pass it. The cache, the memory controller and the network fabric sit outside this block.

Top module: `xfer_engine`

## Requirements
- R1: After reset the engine is idle: `sendBusy`, `recvBusy`, `txValid`, `rdReq`, `wrReq`, `memValid`, `sendDone` and `recvDone` are low, and `cmdReady` is high for every opcode.
- R2: Opcode 1 on `cmdOp` stores `cmdSize` as the byte count. A later send (opcode 2) or receive (opcode 3) uses the most recently stored count. A count stored after a transfer has started does not change that transfer.
- R3: A receive command sends exactly one request packet (`txKind` = 0) to `cmdPeer`. Its `txAddr` equals the receiver's buffer address.
- R4: The sender makes no cache read (`rdReq`) until both conditions hold: a local send has been accepted, and a request packet (`rxKind` = 0) whose `rxSrc` equals the send's peer has been taken in. The two may happen in either order.
- R5: A transfer moves N = max(1, ceil(size/64)) lines of 64 bytes. A size of 0 or of 1 to 64 moves one line. Both `sendDone` and `recvDone` pulse once per transfer, after which both busy flags are low.
- R6: Line i (counting from 0) that hits in the source cache is read from source address + 64*i. It leaves as a packet with `txKind` = 1 and `txAddr` = receiver address + 64*i, and successive lines step the receiver address by 64.
- R7: Line i that misses (`rdHit` low) produces one memory read with `memAddr` = source address + 64*i, `memRequester` = the send's peer and `memTarget` = receiver address + 64*i. No network packet is sent for that line.
- R8: The receiver writes every arriving line packet (`rxKind` = 1) to the cache at that packet's `rxAddr` with its data. It pulses `recvDone` after the N-th write. Line packets are refused (`rxReady` low) while no receive is in progress.
- R9: A send command issued while `sendBusy` is high is stalled (`cmdReady` low) and does not change the running transfer. The same applies to a receive command while `recvBusy` is high.
- R10: `txValid`, `memValid` and `rdReq` stay asserted with stable address and kind until their handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | 1 size, 2 send, 3 receive, 0 none |
| cmdAddr | input | ADDR_W | Local buffer address of send or receive |
| cmdPeer | input | ID_W | Remote core of send or receive |
| cmdSize | input | SIZE_W | Byte count for the size command |
| cmdReady | output | 1 | Command accepted this cycle |
| txValid | output | 1 | Outgoing packet present |
| txReady | input | 1 | Network takes the packet |
| txKind | output | 1 | 0 request, 1 line |
| txDest | output | ID_W | Destination core |
| txAddr | output | ADDR_W | Receiver-side address |
| txData | output | 8*LINE_BYTES | Line data (zero for requests) |
| rxValid | input | 1 | Incoming packet present |
| rxReady | output | 1 | Engine takes the incoming packet |
| rxKind | input | 1 | 0 request, 1 line |
| rxSrc | input | ID_W | Source core of incoming packet |
| rxAddr | input | ADDR_W | Address carried in the packet |
| rxData | input | 8*LINE_BYTES | Line data |
| rdReq | output | 1 | Cache line read request |
| rdAddr | output | ADDR_W | Line address to read |
| rdAck | input | 1 | Read response present |
| rdHit | input | 1 | Response is a hit |
| rdData | input | 8*LINE_BYTES | Line data on a hit |
| wrReq | output | 1 | Cache line write request |
| wrAddr | output | ADDR_W | Line address to write |
| wrData | output | 8*LINE_BYTES | Line data to write |
| wrAck | input | 1 | Write completed |
| memValid | output | 1 | Redirected memory read present |
| memReady | input | 1 | Memory controller takes the read |
| memAddr | output | ADDR_W | Source line address |
| memRequester | output | ID_W | Core that gets the reply |
| memTarget | output | ADDR_W | Address at the receiving core |
| sendBusy | output | 1 | Send transfer in progress |
| recvBusy | output | 1 | Receive transfer in progress |
| sendDone | output | 1 | One-cycle pulse at end of send |
| recvDone | output | 1 | One-cycle pulse at end of receive |

## Verification
The bench loops the engine's own packets back to it and answers cache reads and memory reads from a model. A design that forgot the rendezvous would read the cache as soon as the send arrived, so the bench holds the request back and watches `rdReq`. Sizes of 0, 1, 64, 65 and multiples of the line size are used. An off-by-one line count would show up as a missing or extra write, and a counter that tested equality instead of reaching-or-passing would never finish on 65 or 200. Miss patterns interleave hits and misses. A design that sent a missed line over the network, or gave memory the source address as target, would put wrong data or addresses into the receiver's writes. Backpressure on the network and memory ports checks that the request and line packets hold steady. A second send while busy, and line packets arriving with no receive in progress, must leave the running state untouched.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SIZE = 2'd1,
    OP_SEND = 2'd2,
    OP_RECV = 2'd3
  } op_e;

  localparam logic PKT_REQ  = 1'b0;
  localparam logic PKT_LINE = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic ldSize;   // store byte count
    logic ldSend;   // latch send command
    logic ldRecv;   // latch receive command
    logic capReq;   // take an incoming request into the slot
    logic takeReq;  // consume slot, start streaming
    logic capLine;  // capture cache read data
    logic advSend;  // one source line finished
    logic capRx;    // capture an incoming line packet
    logic advRecv;  // one destination line written
  } strobe_t;

endpackage

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int SIZE_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic [ID_W-1:0]           cmdPeer,
  input  logic [SIZE_W-1:0]         cmdSize,
  input  logic [ID_W-1:0]           rxSrc,
  input  logic [ADDR_W-1:0]         rxAddr,
  input  logic [LINE_BYTES*8-1:0]   rxData,
  input  logic [LINE_BYTES*8-1:0]   rdData,
  output logic                      reqPending,
  output logic                      reqMatch,
  output logic                      sendLast,
  output logic                      recvLast,
  output logic [ADDR_W-1:0]         srcAddr,
  output logic [ADDR_W-1:0]         dstAddr,
  output logic [ID_W-1:0]           sendPeer,
  output logic [ID_W-1:0]           recvPeer,
  output logic [ADDR_W-1:0]         recvAddr,
  output logic [LINE_BYTES*8-1:0]   lineBuf,
  output logic [ADDR_W-1:0]         wrAddr,
  output logic [LINE_BYTES*8-1:0]   wrData
);

  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int CNT_W     = SIZE_W + 1;
  localparam logic [CNT_W-1:0]  STEP_CNT  = CNT_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(LINE_BYTES);

  logic [CNT_W-1:0]  sizeReg;
  logic [CNT_W-1:0]  sendSize;
  logic [CNT_W-1:0]  recvSize;
  logic [CNT_W-1:0]  sentBytes;
  logic [CNT_W-1:0]  gotBytes;
  logic [ID_W-1:0]   reqSrc;
  logic [ADDR_W-1:0] reqAddr;

  // byte count register
  always_ff @(posedge clk) begin
    if (!rstN)           sizeReg <= '0;
    else if (stb.ldSize) sizeReg <= {1'b0, cmdSize};
  end

  // incoming request slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPending <= 1'b0;
      reqSrc     <= '0;
      reqAddr    <= '0;
    end else if (stb.capReq) begin
      reqPending <= 1'b1;
      reqSrc     <= rxSrc;
      reqAddr    <= rxAddr;
    end else if (stb.takeReq) begin
      reqPending <= 1'b0;
    end
  end

  assign reqMatch = reqPending && (reqSrc == sendPeer);

  // sender side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendPeer  <= '0;
      srcAddr   <= '0;
      dstAddr   <= '0;
      sendSize  <= '0;
      sentBytes <= '0;
    end else begin
      if (stb.ldSend) begin
        sendPeer  <= cmdPeer;
        srcAddr   <= cmdAddr;
        sendSize  <= sizeReg;
        sentBytes <= '0;
      end
      if (stb.takeReq) dstAddr <= reqAddr;
      if (stb.advSend) begin
        sentBytes <= sentBytes + STEP_CNT;
        srcAddr   <= srcAddr + STEP_ADDR;
        dstAddr   <= dstAddr + STEP_ADDR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            lineBuf <= '0;
    else if (stb.capLine) lineBuf <= rdData;
  end

  // line being moved now is the last once the count reaches or passes the size
  assign sendLast = (sentBytes + STEP_CNT) >= sendSize;

  // receiver side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      recvPeer <= '0;
      recvAddr <= '0;
      recvSize <= '0;
      gotBytes <= '0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      if (stb.ldRecv) begin
        recvPeer <= cmdPeer;
        recvAddr <= cmdAddr;
        recvSize <= sizeReg;
        gotBytes <= '0;
      end
      if (stb.capRx) begin
        wrAddr <= rxAddr;
        wrData <= rxData[LINE_BITS-1:0];
      end
      if (stb.advRecv) gotBytes <= gotBytes + STEP_CNT;
    end
  end

  assign recvLast = (gotBytes + STEP_CNT) >= recvSize;

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic [1:0] cmdOp,
  output logic    cmdReady,
  input  logic    txReady,
  output logic    txValid,
  output logic    txReqSel,
  input  logic    rxValid,
  input  logic    rxKind,
  output logic    rxReady,
  output logic    rdReq,
  input  logic    rdAck,
  input  logic    rdHit,
  output logic    wrReq,
  input  logic    wrAck,
  output logic    memValid,
  input  logic    memReady,
  input  logic    reqPending,
  input  logic    reqMatch,
  input  logic    sendLast,
  input  logic    recvLast,
  output strobe_t stb,
  output logic    sendBusy,
  output logic    recvBusy,
  output logic    sendDone,
  output logic    recvDone
);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_RD, S_TX, S_MEM} send_e;
  typedef enum logic [1:0] {R_IDLE, R_REQ, R_WAIT, R_WR} recv_e;

  send_e sendState, sendNext;
  recv_e recvState, recvNext;
  logic  lineHeld;
  logic  showLine;
  logic  cmdFire;
  logic  rxFire;
  logic  lineGrant;

  assign sendBusy = (sendState != S_IDLE);
  assign recvBusy = (recvState != R_IDLE);

  always_comb begin
    unique case (op_e'(cmdOp))
      OP_SEND: cmdReady = !sendBusy;
      OP_RECV: cmdReady = !recvBusy;
      default: cmdReady = 1'b1;
    endcase
  end
  assign cmdFire = cmdValid && cmdReady;

  // network output arbitration: a line already on offer keeps the port
  assign txReqSel  = (recvState == R_REQ) && !lineHeld;
  assign showLine  = (sendState == S_TX) && !txReqSel;
  assign txValid   = txReqSel || showLine;
  assign lineGrant = showLine && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) lineHeld <= 1'b0;
    else       lineHeld <= showLine && !txReady;
  end

  assign rxReady = (rxKind == PKT_REQ) ? !reqPending : (recvState == R_WAIT);
  assign rxFire  = rxValid && rxReady;

  assign rdReq    = (sendState == S_RD);
  assign memValid = (sendState == S_MEM);
  assign wrReq    = (recvState == R_WR);

  always_comb begin
    stb         = '0;
    stb.ldSize  = cmdFire && (op_e'(cmdOp) == OP_SIZE);
    stb.ldSend  = cmdFire && (op_e'(cmdOp) == OP_SEND);
    stb.ldRecv  = cmdFire && (op_e'(cmdOp) == OP_RECV);
    stb.capReq  = rxFire && (rxKind == PKT_REQ);
    stb.takeReq = (sendState == S_ARM) && reqMatch;
    stb.capLine = (sendState == S_RD) && rdAck;
    stb.advSend = ((sendState == S_TX) && lineGrant) ||
                  ((sendState == S_MEM) && memReady);
    stb.capRx   = rxFire && (rxKind == PKT_LINE);
    stb.advRecv = (recvState == R_WR) && wrAck;
  end

  // sender sequence
  always_comb begin
    sendNext = sendState;
    unique case (sendState)
      S_IDLE: if (stb.ldSend)  sendNext = S_ARM;
      S_ARM:  if (stb.takeReq) sendNext = S_RD;
      S_RD:   if (rdAck)       sendNext = rdHit ? S_TX : S_MEM;
      S_TX, S_MEM:
              if (stb.advSend) sendNext = sendLast ? S_IDLE : S_RD;
      default: sendNext = S_IDLE;
    endcase
  end

  // receiver sequence
  always_comb begin
    recvNext = recvState;
    unique case (recvState)
      R_IDLE: if (stb.ldRecv)            recvNext = R_REQ;
      R_REQ:  if (txReqSel && txReady)   recvNext = R_WAIT;
      R_WAIT: if (stb.capRx)             recvNext = R_WR;
      R_WR:   if (stb.advRecv)           recvNext = recvLast ? R_IDLE : R_WAIT;
      default: recvNext = R_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendState <= S_IDLE;
      recvState <= R_IDLE;
      sendDone  <= 1'b0;
      recvDone  <= 1'b0;
    end else begin
      sendState <= sendNext;
      recvState <= recvNext;
      sendDone  <= stb.advSend && sendLast;
      recvDone  <= stb.advRecv && recvLast;
    end
  end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int SIZE_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdOp,
  input  logic [ADDR_W-1:0]       cmdAddr,
  input  logic [ID_W-1:0]         cmdPeer,
  input  logic [SIZE_W-1:0]       cmdSize,
  output logic                    cmdReady,
  output logic                    txValid,
  input  logic                    txReady,
  output logic                    txKind,
  output logic [ID_W-1:0]         txDest,
  output logic [ADDR_W-1:0]       txAddr,
  output logic [LINE_BYTES*8-1:0] txData,
  input  logic                    rxValid,
  output logic                    rxReady,
  input  logic                    rxKind,
  input  logic [ID_W-1:0]         rxSrc,
  input  logic [ADDR_W-1:0]       rxAddr,
  input  logic [LINE_BYTES*8-1:0] rxData,
  output logic                    rdReq,
  output logic [ADDR_W-1:0]       rdAddr,
  input  logic                    rdAck,
  input  logic                    rdHit,
  input  logic [LINE_BYTES*8-1:0] rdData,
  output logic                    wrReq,
  output logic [ADDR_W-1:0]       wrAddr,
  output logic [LINE_BYTES*8-1:0] wrData,
  input  logic                    wrAck,
  output logic                    memValid,
  input  logic                    memReady,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ID_W-1:0]         memRequester,
  output logic [ADDR_W-1:0]       memTarget,
  output logic                    sendBusy,
  output logic                    recvBusy,
  output logic                    sendDone,
  output logic                    recvDone
);

  strobe_t                 stb;
  logic                    reqPending, reqMatch, sendLast, recvLast;
  logic                    txReqSel;
  logic [ADDR_W-1:0]       srcAddr, dstAddr, recvAddr;
  logic [ID_W-1:0]         sendPeer, recvPeer;
  logic [LINE_BYTES*8-1:0] lineBuf;

  xfer_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReady(cmdReady),
    .txReady(txReady), .txValid(txValid), .txReqSel(txReqSel),
    .rxValid(rxValid), .rxKind(rxKind), .rxReady(rxReady),
    .rdReq(rdReq), .rdAck(rdAck), .rdHit(rdHit),
    .wrReq(wrReq), .wrAck(wrAck),
    .memValid(memValid), .memReady(memReady),
    .reqPending(reqPending), .reqMatch(reqMatch),
    .sendLast(sendLast), .recvLast(recvLast),
    .stb(stb),
    .sendBusy(sendBusy), .recvBusy(recvBusy),
    .sendDone(sendDone), .recvDone(recvDone)
  );

  xfer_dp #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdAddr(cmdAddr), .cmdPeer(cmdPeer), .cmdSize(cmdSize),
    .rxSrc(rxSrc), .rxAddr(rxAddr), .rxData(rxData), .rdData(rdData),
    .reqPending(reqPending), .reqMatch(reqMatch),
    .sendLast(sendLast), .recvLast(recvLast),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .sendPeer(sendPeer), .recvPeer(recvPeer), .recvAddr(recvAddr),
    .lineBuf(lineBuf), .wrAddr(wrAddr), .wrData(wrData)
  );

  // network output: request packet or data line
  assign txKind = txReqSel ? PKT_REQ : PKT_LINE;
  assign txDest = txReqSel ? recvPeer : sendPeer;
  assign txAddr = txReqSel ? recvAddr : dstAddr;
  assign txData = txReqSel ? '0 : lineBuf;

  // local cache read and redirected memory read
  assign rdAddr       = srcAddr;
  assign memAddr      = srcAddr;
  assign memRequester = sendPeer;
  assign memTarget    = dstAddr;

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              cmdReady,
  input logic              txValid,
  input logic              txReady,
  input logic              txKind,
  input logic [ID_W-1:0]   txDest,
  input logic [ADDR_W-1:0] txAddr,
  input logic              rxValid,
  input logic              rxKind,
  input logic              rxReady,
  input logic              rdReq,
  input logic              rdAck,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memTarget,
  input logic              sendBusy,
  input logic              recvBusy
);

  logic              lineOut;
  logic [ADDR_W-1:0] lineTgt;
  logic              haveLast;
  logic [ADDR_W-1:0] lastTgt;

  assign lineOut = (txValid && txReady && txKind) || (memValid && memReady);
  assign lineTgt = memValid ? memTarget : txAddr;

  always_ff @(posedge clk) begin
    if (!rstN || !sendBusy) begin
      haveLast <= 1'b0;
      lastTgt  <= '0;
    end else if (lineOut) begin
      haveLast <= 1'b1;
      lastTgt  <= lineTgt;
    end
  end

  AST_SEND_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2 && sendBusy) |-> !cmdReady);  // R9

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txAddr) && $stable(txKind) && $stable(txDest)));  // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memTarget)));  // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));  // R10

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lineOut && haveLast) |-> (lineTgt == lastTgt + ADDR_W'(LINE_BYTES)));  // R6

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdReq, txValid && txKind, memValid}));  // R7

  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> sendBusy);  // R4

  AST_RX_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxKind && !recvBusy) |-> !rxReady);  // R8

endmodule

bind xfer_engine xfer_engine_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .LINE_BYTES(LINE_BYTES)
) uChk (
  .clk(clk), .rstN(rstN),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReady(cmdReady),
  .txValid(txValid), .txReady(txReady), .txKind(txKind), .txDest(txDest), .txAddr(txAddr),
  .rxValid(rxValid), .rxKind(rxKind), .rxReady(rxReady),
  .rdReq(rdReq), .rdAck(rdAck), .rdAddr(rdAddr),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memTarget(memTarget),
  .sendBusy(sendBusy), .recvBusy(recvBusy)
);

// File: tb/sim_xfer_engine.sv
`timescale 1ns/1ps
module sim_xfer_engine;

  localparam int AW = 32;
  localparam int IW = 4;
  localparam int SW = 16;
  localparam int LB = 64;
  localparam int DW = LB * 8;
  localparam logic [IW-1:0] MY_ID = 4'd3;

  // {sendFirst, stall, missMask[7:0], size[15:0], src[31:0], dst[31:0]}
  localparam logic [89:0] VEC [8] = '{
    {1'b0, 1'b0, 8'h00, 16'd64,  32'h0000_1000, 32'h0000_8000},
    {1'b0, 1'b0, 8'h00, 16'd1,   32'h0000_2040, 32'h0000_9000},
    {1'b0, 1'b0, 8'h01, 16'd65,  32'h0000_3000, 32'h0000_A0C0},
    {1'b1, 1'b0, 8'hAA, 16'd200, 32'h0000_4000, 32'h0000_B000},
    {1'b0, 1'b1, 8'hFF, 16'd512, 32'h0001_0000, 32'h0002_0000},
    {1'b0, 1'b0, 8'h00, 16'd0,   32'h0000_5000, 32'h0000_C000},
    {1'b1, 1'b1, 8'h00, 16'd128, 32'h0000_6000, 32'h0000_D000},
    {1'b0, 1'b1, 8'h0F, 16'd300, 32'h0000_7000, 32'h0000_E000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [AW-1:0] cmdAddr = '0;
  logic [IW-1:0] cmdPeer = '0;
  logic [SW-1:0] cmdSize = '0;
  logic cmdReady;
  logic txValid, txKind;
  logic txReady = 1'b1;
  logic [IW-1:0] txDest;
  logic [AW-1:0] txAddr;
  logic [DW-1:0] txData;
  logic rxValid = 1'b0;
  logic rxReady;
  logic rxKind = 1'b0;
  logic [IW-1:0] rxSrc = '0;
  logic [AW-1:0] rxAddr = '0;
  logic [DW-1:0] rxData = '0;
  logic rdReq;
  logic [AW-1:0] rdAddr;
  logic rdAck = 1'b0;
  logic rdHit = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic wrReq;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic wrAck = 1'b0;
  logic memValid;
  logic memReady = 1'b1;
  logic [AW-1:0] memAddr, memTarget;
  logic [IW-1:0] memRequester;
  logic sendBusy, recvBusy, sendDone, recvDone;

  always #2 clk = ~clk;

  xfer_engine #(.ADDR_W(AW), .ID_W(IW), .SIZE_W(SW), .LINE_BYTES(LB)) u0 (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdPeer(cmdPeer),
    .cmdSize(cmdSize), .cmdReady(cmdReady),
    .txValid(txValid), .txReady(txReady), .txKind(txKind), .txDest(txDest),
    .txAddr(txAddr), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxKind(rxKind), .rxSrc(rxSrc),
    .rxAddr(rxAddr), .rxData(rxData),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdHit(rdHit), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memRequester(memRequester), .memTarget(memTarget),
    .sendBusy(sendBusy), .recvBusy(recvBusy), .sendDone(sendDone), .recvDone(recvDone)
  );

  int nChecks = 0;
  int nFails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {16{a ^ 32'h5A5A_0F0F}};
  endfunction

  // state of the transfer under test, shared with the network model
  logic [AW-1:0] curSrc = '0, curDst = '0;
  logic [7:0]    curMask = '0;
  int  curN = 0;
  bit  stallMode = 1'b0;
  bit  injOn = 1'b0;
  int  wrIdx = 0, memCnt = 0, lineTxCnt = 0, reqCnt = 0;
  int  sendDoneCnt = 0, recvDoneCnt = 0;
  int  cyc = 0;

  // loopback network, cache and memory model
  logic          qKind [16];
  logic [AW-1:0] qAddr [16];
  logic [DW-1:0] qData [16];
  int qHead = 0, qTail = 0, qCnt = 0;
  bit fTx = 0, fMem = 0, fRx = 0, fWr = 0;
  logic          sKind;
  logic [IW-1:0] sDest, sReqr;
  logic [AW-1:0] sAddr, sMemA, sMemT, sWrA;
  logic [DW-1:0] sData, sWrD;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (sendDone) sendDoneCnt++;
      if (recvDone) recvDoneCnt++;
      if (fTx) begin
        if (sKind == 1'b0) begin
          reqCnt++;
          chk(sAddr == curDst, "R3 request address", longint'(sAddr), longint'(curDst));
          chk(sDest == MY_ID, "R3 request destination", longint'(sDest), longint'(MY_ID));
        end else begin
          lineTxCnt++;
        end
        qKind[qTail] = sKind; qAddr[qTail] = sAddr; qData[qTail] = sData;
        qTail = (qTail + 1) % 16; qCnt++;
      end
      if (fMem) begin
        memCnt++;
        chk(sReqr == MY_ID, "R7 memory requester", longint'(sReqr), longint'(MY_ID));
        qKind[qTail] = 1'b1; qAddr[qTail] = sMemT; qData[qTail] = pat(sMemA);
        qTail = (qTail + 1) % 16; qCnt++;
      end
      if (fRx) begin
        qHead = (qHead + 1) % 16; qCnt--;
      end
      if (fWr) begin
        chk(wrIdx < curN, "R5 write count bound", longint'(wrIdx), longint'(curN));
        chk(sWrA == curDst + AW'(64 * wrIdx), "R8 write address",
            longint'(sWrA), longint'(curDst + AW'(64 * wrIdx)));
        chk(sWrD == pat(curSrc + AW'(64 * wrIdx)), "R6 write data",
            longint'(sWrD[31:0]), longint'(pat(curSrc + AW'(64 * wrIdx))[31:0]));
        wrIdx++;
      end
      // drive inputs for the coming edge
      if (injOn) begin
        rxValid = 1'b1; rxKind = 1'b1; rxSrc = MY_ID; rxAddr = 32'h0000_F000; rxData = pat(32'h0);
      end else if (qCnt > 0) begin
        rxValid = 1'b1; rxKind = qKind[qHead]; rxSrc = MY_ID;
        rxAddr = qAddr[qHead]; rxData = qData[qHead];
      end else begin
        rxValid = 1'b0; rxKind = 1'b0;
      end
      if (rdReq && !rdAck) begin
        rdAck  = 1'b1;
        rdHit  = !curMask[((rdAddr - curSrc) / 64) % 8];
        rdData = pat(rdAddr);
      end else begin
        rdAck = 1'b0;
      end
      wrAck    = wrReq && !wrAck;
      txReady  = stallMode ? cyc[0] : 1'b1;
      memReady = stallMode ? !cyc[0] : 1'b1;
      #1;
      fTx = txValid && txReady;
      sKind = txKind; sDest = txDest; sAddr = txAddr; sData = txData;
      fMem = memValid && memReady;
      sMemA = memAddr; sMemT = memTarget; sReqr = memRequester;
      fRx = rxValid && rxReady && !injOn;
      fWr = wrReq && wrAck;
      sWrA = wrAddr; sWrD = wrData;
    end
  end

  task automatic doCmd(input logic [1:0] op, input logic [AW-1:0] a, input logic [SW-1:0] sz);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdPeer = MY_ID; cmdSize = sz;
    #1;
    while (!cmdReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic startXfer(input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input logic [7:0] m, input int n, input bit st);
    curSrc = s; curDst = d; curMask = m; curN = n; stallMode = st;
    wrIdx = 0; memCnt = 0; lineTxCnt = 0; reqCnt = 0;
    sendDoneCnt = 0; recvDoneCnt = 0;
  endtask

  task automatic finishXfer(input string tag);
    int expMiss;
    expMiss = 0;
    for (int i = 0; i < curN; i++) if (curMask[i % 8]) expMiss++;
    while (sendDoneCnt == 0 || recvDoneCnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
    chk(wrIdx == curN, {tag, " R5 lines written"}, longint'(wrIdx), longint'(curN));
    chk(memCnt == expMiss, {tag, " R7 memory reads"}, longint'(memCnt), longint'(expMiss));
    chk(lineTxCnt == curN - expMiss, {tag, " R6 network lines"},
        longint'(lineTxCnt), longint'(curN - expMiss));
    chk(reqCnt == 1, {tag, " R3 request count"}, longint'(reqCnt), 1);
    chk(sendDoneCnt == 1 && recvDoneCnt == 1, {tag, " R5 done pulses"},
        longint'(sendDoneCnt * 16 + recvDoneCnt), 17);
    chk(!sendBusy && !recvBusy, {tag, " R5 idle after"}, longint'({sendBusy, recvBusy}), 0);
  endtask

  function automatic int lines(input int sz);
    return (sz == 0) ? 1 : (sz + 63) / 64;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!sendBusy && !recvBusy && !txValid && !rdReq && !wrReq && !memValid && !sendDone && !recvDone,
        "R1 idle outputs after reset",
        longint'({sendBusy, recvBusy, txValid, rdReq, wrReq, memValid, sendDone, recvDone}), 0);
    cmdOp = 2'd2; #0.1;
    chk(cmdReady, "R1 send ready in reset", longint'(cmdReady), 1);
    cmdOp = 2'd3; #0.1;
    chk(cmdReady, "R1 receive ready in reset", longint'(cmdReady), 1);
    cmdOp = 2'd0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table of transfers
    for (int v = 0; v < 8; v++) begin
      logic [89:0] e;
      e = VEC[v];
      startXfer(e[63:32], e[31:0], e[87:80], lines(int'(e[79:64])), e[88]);
      doCmd(2'd1, '0, e[79:64]);
      if (e[89]) begin
        doCmd(2'd2, e[63:32], '0);
        repeat (6) @(negedge clk);
        doCmd(2'd3, e[31:0], '0);
      end else begin
        doCmd(2'd3, e[31:0], '0);
        doCmd(2'd2, e[63:32], '0);
      end
      finishXfer($sformatf("vec%0d", v));
    end

    // R4 and R9: send waits for the request; a second send is stalled
    startXfer(32'h0000_3400, 32'h0000_7400, 8'h02, 2, 1'b0);
    doCmd(2'd1, '0, 16'd100);
    doCmd(2'd2, 32'h0000_3400, '0);
    begin
      bit sawRd;
      sawRd = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); #1;
        if (rdReq) sawRd = 1'b1;
      end
      chk(!sawRd, "R4 no read before request", longint'(sawRd), 0);
    end
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd2; cmdAddr = 32'h0000_9900; cmdPeer = MY_ID;
    #1;
    chk(!cmdReady, "R9 second send stalled", longint'(cmdReady), 0);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
    doCmd(2'd3, 32'h0000_7400, '0);
    finishXfer("r4_r9");

    // R4 other order: request first, no read until send
    startXfer(32'h0000_4400, 32'h0000_6400, 8'h00, 3, 1'b0);
    doCmd(2'd1, '0, 16'd150);
    doCmd(2'd3, 32'h0000_6400, '0);
    begin
      bit sawRd;
      sawRd = 1'b0;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk); #1;
        if (rdReq) sawRd = 1'b1;
      end
      chk(!sawRd, "R4 no read before send", longint'(sawRd), 0);
    end
    doCmd(2'd2, 32'h0000_4400, '0);
    finishXfer("r4_rev");

    // R2: the last stored count wins; a count stored mid-transfer is ignored
    startXfer(32'h0000_5400, 32'h0000_5800, 8'h00, 3, 1'b1);
    doCmd(2'd1, '0, 16'd500);
    doCmd(2'd1, '0, 16'd130);
    doCmd(2'd3, 32'h0000_5800, '0);
    doCmd(2'd2, 32'h0000_5400, '0);
    doCmd(2'd1, '0, 16'd1000);
    finishXfer("r2_size");

    // R8: line packet with no receive in progress is refused
    startXfer(32'h0, 32'h0, 8'h00, 0, 1'b0);
    @(negedge clk);
    injOn = 1'b1;
    begin
      bit took;
      took = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); #1;
        if (rxValid && rxReady) took = 1'b1;
        if (wrReq) took = 1'b1;
      end
      chk(!took, "R8 line refused while idle", longint'(took), 0);
    end
    injOn = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(wrIdx == 0 && !recvBusy, "R8 no write from refused line", longint'(wrIdx), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule